// File: doc/BRIEF.md
# Event-Synchronous Stream Merger

This block takes up to four independent word streams and joins them into a single stream in which every event appears as one contiguous block. Each word carries a 21-bit payload and two marker bits: one closes a packet, the other closes an event. Packets have variable length. A sender pushes a word with a one-cycle valid strobe and must stop while the block raises that lane's hold line. Every lane has its own 16-entry buffer, so a lane can run ahead of the others by part of an event or more.

For each event the block visits the enabled lanes in ascending index order. It forwards a lane's words until that lane's end-of-event word arrives. The lane's end-of-event word is consumed and not forwarded. Once the last enabled lane has closed the event, the block emits one end-of-event word of its own. The joined stream drives two identical output copies, and it advances only while neither downstream receiver is holding. The lane-enable mask is taken at the start of each event.

Top module: `evm_merger`

## Requirements
- R1: While reset is active and in the first cycle after it, both output copies show valid low and every input hold line is low.
- R2: A forwarded word keeps its 21-bit payload and its end-of-packet bit unchanged, for packets of any length from one word up.
- R3: Within one event, output words come from the enabled lanes in ascending lane index. Each lane's words keep their arrival order and run up to that lane's end-of-event word.
- R4: A lane's end-of-event word (end-of-event bit set) is never forwarded. After the last enabled lane finishes, exactly one word with payload 0, end-of-packet 0 and end-of-event 1 is emitted, and no other output word has the end-of-event bit set.
- R5: The two output copies carry equal valid, payload and marker values in every cycle.
- R6: A word is taken by the receivers on a clock edge where valid is high and both output hold inputs are low. While either hold is high, the presented word and its valid stay unchanged.
- R7: A lane's hold line goes high once its buffer holds 12 or more words, whatever the state of the outputs. With 11 or fewer words and the lane not being drained, it stays low.
- R8: While the block is draining a lane and either output hold is high, that lane's hold line is high even if its buffer is nearly empty. Hold lines of other lanes are not raised by this.
- R9: Words that a lane delivers for the next event, after its end-of-event word, stay buffered. They are emitted only after the current event's end-of-event output word.
- R10: The enable mask (bit i enables lane i) is sampled when an event starts and held for that whole event. With an all-zero mask no word is emitted, and words already written stay buffered until an event enables their lane.
- R11: With senders that obey hold, no word is lost or duplicated: every non-marker input word of an enabled lane appears exactly once at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_enable | input | NUM_IN | Lane enable mask, sampled at event start |
| in_valid | input | NUM_IN | Per-lane word strobe |
| in_data | input | NUM_IN x 21 | Per-lane payload |
| in_eop | input | NUM_IN | Per-lane end-of-packet bit |
| in_eoe | input | NUM_IN | Per-lane end-of-event bit |
| in_hold | output | NUM_IN | Per-lane flow-control hold back to the sender |
| out0_valid | output | 1 | Copy 0 word valid |
| out0_data | output | 21 | Copy 0 payload |
| out0_eop | output | 1 | Copy 0 end-of-packet bit |
| out0_eoe | output | 1 | Copy 0 end-of-event bit |
| out0_hold | input | 1 | Hold from copy 0 receiver |
| out1_valid | output | 1 | Copy 1 word valid |
| out1_data | output | 21 | Copy 1 payload |
| out1_eop | output | 1 | Copy 1 end-of-packet bit |
| out1_eoe | output | 1 | Copy 1 end-of-event bit |
| out1_hold | input | 1 | Hold from copy 1 receiver |

## Verification
The assertions assume that a sender never strobes a word into a lane whose buffer is already full. They also assume that a lane's end-of-event word eventually follows its data, so that draining never reads an empty buffer. The stimulus honours this because each driver checks the lane's hold line in the cycle before it strobes and leaves it low while hold is high. Hold rises at 12 entries, well below the 16-entry capacity. Every generated lane event ends with an end-of-event word, and no lane ever carries more than 14 words at once. Enable masks are changed only while the block waits at an event boundary, or after the event that uses them has started.

// File: rtl/evm_pkg.sv
package evm_pkg;

    localparam int WORD_W = 21;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              eop;
        logic              eoe;
    } evm_word_t;

    typedef enum logic [1:0] {
        SQ_START,
        SQ_SCAN,
        SQ_DRAIN,
        SQ_EMIT
    } evm_seq_e;

endpackage

// File: rtl/evm_in_fifo.sv
module evm_in_fifo
    import evm_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HOLD_AT = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  evm_word_t wr_word,
    input  logic      rd_en,
    output evm_word_t rd_word,
    output logic      empty,
    output logic      hold_lvl
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t  fs_q, fs_d;
    evm_word_t mem_q [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fs_d = fs_q;
        if (wr_en) fs_d.wptr = bump(fs_q.wptr);
        if (rd_en) fs_d.rptr = bump(fs_q.rptr);
        case ({wr_en, rd_en})
            2'b10:   fs_d.count = fs_q.count + 1'b1;
            2'b01:   fs_d.count = fs_q.count - 1'b1;
            default: fs_d.count = fs_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[fs_q.wptr] <= wr_word;
    end

    assign rd_word  = mem_q[fs_q.rptr];
    assign empty    = (fs_q.count == '0);
    assign hold_lvl = (fs_q.count >= CW'(HOLD_AT));

    // R11: a sender that obeys hold never writes into a full buffer
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fs_q.count < CW'(DEPTH)));

    // R11: the sequencer only pops a lane that holds data
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    // R7: the fill-level hold can only rise after a write
    a_r7_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_lvl) |-> $past(wr_en));

endmodule

// File: rtl/evm_seq.sv
module evm_seq
    import evm_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IN-1:0]      enable,
    input  logic [NUM_IN-1:0]      fifo_empty,
    input  evm_word_t [NUM_IN-1:0] head,
    input  logic                   accept,
    output logic [NUM_IN-1:0]      pop,
    output logic                   load,
    output evm_word_t              load_word,
    output logic [NUM_IN-1:0]      serving
);

    localparam int SW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int IW = $clog2(NUM_IN + 1);

    typedef struct packed {
        evm_seq_e          st;
        logic [NUM_IN-1:0] mask;
        logic [IW-1:0]     idx;
        logic [SW-1:0]     sel;
    } seq_st_t;

    seq_st_t   sq_q, sq_d;
    evm_word_t cur;

    assign cur = head[sq_q.sel];

    always_comb begin
        sq_d      = sq_q;
        pop       = '0;
        load      = 1'b0;
        load_word = '0;
        case (sq_q.st)
            SQ_START: begin
                if (|enable) begin
                    sq_d.mask = enable;
                    sq_d.idx  = '0;
                    sq_d.st   = SQ_SCAN;
                end
            end
            SQ_SCAN: begin
                if (sq_q.idx == IW'(NUM_IN)) begin
                    sq_d.st = SQ_EMIT;
                end else if (sq_q.mask[sq_q.idx[SW-1:0]]) begin
                    sq_d.sel = sq_q.idx[SW-1:0];
                    sq_d.st  = SQ_DRAIN;
                end else begin
                    sq_d.idx = sq_q.idx + 1'b1;
                end
            end
            SQ_DRAIN: begin
                if (!fifo_empty[sq_q.sel] && accept) begin
                    pop[sq_q.sel] = 1'b1;
                    if (cur.eoe) begin
                        sq_d.idx = IW'(sq_q.sel) + 1'b1;
                        sq_d.st  = SQ_SCAN;
                    end else begin
                        load           = 1'b1;
                        load_word.data = cur.data;
                        load_word.eop  = cur.eop;
                    end
                end
            end
            SQ_EMIT: begin
                if (accept) begin
                    load          = 1'b1;
                    load_word.eoe = 1'b1;
                    sq_d.st       = SQ_START;
                end
            end
            default: sq_d.st = SQ_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '{st: SQ_START, mask: '0, idx: '0, sel: '0};
        else        sq_q <= sq_d;
    end

    always_comb begin
        serving = '0;
        if (sq_q.st == SQ_DRAIN) serving[sq_q.sel] = 1'b1;
    end

    // R3: at most one lane is popped per cycle
    a_r3_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    // R3: only the lane being drained may be popped
    a_r3_pop_serving: assert property (@(posedge clk) disable iff (!rst_n)
        (|pop) |-> (pop == serving));

    // R4: an emitted end-of-event word closes the event
    a_r4_emit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == SQ_EMIT && accept) |=> (sq_q.st == SQ_START));

    // R4: lane end-of-event words are never loaded into the output
    a_r4_eoe_only_emitted: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_word.eoe) |-> (sq_q.st == SQ_EMIT));

    // R10: the event mask is frozen outside the event-start state
    a_r10_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st != SQ_START) |=> $stable(sq_q.mask));

endmodule

// File: rtl/evm_out_stage.sv
module evm_out_stage
    import evm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  evm_word_t load_word,
    input  logic      hold_a,
    input  logic      hold_b,
    output logic      accept,
    output logic      out_valid,
    output evm_word_t out_word
);

    typedef struct packed {
        logic      valid;
        evm_word_t word;
    } out_st_t;

    out_st_t os_q, os_d;
    logic    stall;

    always_comb begin
        stall  = hold_a | hold_b;
        accept = !os_q.valid || !stall;
        os_d   = os_q;
        if (accept) begin
            os_d.valid = load;
            if (load) os_d.word = load_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) os_q <= '0;
        else        os_q <= os_d;
    end

    assign out_valid = os_q.valid;
    assign out_word  = os_q.word;

    // R6: a held word stays presented unchanged
    a_r6_hold_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (os_q.valid && (hold_a || hold_b)) |=> (os_q.valid && $stable(os_q.word)));

    // R6: the sequencer never offers a word the stage cannot take
    a_r6_load_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> accept);

endmodule

// File: rtl/evm_merger.sv
module evm_merger
    import evm_pkg::*;
#(
    parameter int NUM_IN     = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int HOLD_AT    = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_IN-1:0]            in_enable,
    input  logic [NUM_IN-1:0]            in_valid,
    input  logic [NUM_IN-1:0][WORD_W-1:0] in_data,
    input  logic [NUM_IN-1:0]            in_eop,
    input  logic [NUM_IN-1:0]            in_eoe,
    output logic [NUM_IN-1:0]            in_hold,
    output logic                         out0_valid,
    output logic [WORD_W-1:0]            out0_data,
    output logic                         out0_eop,
    output logic                         out0_eoe,
    input  logic                         out0_hold,
    output logic                         out1_valid,
    output logic [WORD_W-1:0]            out1_data,
    output logic                         out1_eop,
    output logic                         out1_eoe,
    input  logic                         out1_hold
);

    evm_word_t [NUM_IN-1:0] head;
    logic [NUM_IN-1:0]      fifo_empty;
    logic [NUM_IN-1:0]      fifo_lvl;
    logic [NUM_IN-1:0]      pop;
    logic [NUM_IN-1:0]      serving;
    logic                   load;
    evm_word_t              load_word;
    logic                   accept;
    logic                   ovalid;
    evm_word_t              oword;
    logic                   out_stall;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
        evm_word_t wr_w;
        assign wr_w = '{data: in_data[g], eop: in_eop[g], eoe: in_eoe[g]};

        evm_in_fifo #(
            .DEPTH   (FIFO_DEPTH),
            .HOLD_AT (HOLD_AT)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (in_valid[g]),
            .wr_word  (wr_w),
            .rd_en    (pop[g]),
            .rd_word  (head[g]),
            .empty    (fifo_empty[g]),
            .hold_lvl (fifo_lvl[g])
        );
    end

    evm_seq #(
        .NUM_IN (NUM_IN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (in_enable),
        .fifo_empty (fifo_empty),
        .head       (head),
        .accept     (accept),
        .pop        (pop),
        .load       (load),
        .load_word  (load_word),
        .serving    (serving)
    );

    evm_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .hold_a    (out0_hold),
        .hold_b    (out1_hold),
        .accept    (accept),
        .out_valid (ovalid),
        .out_word  (oword)
    );

    assign out_stall = out0_hold | out1_hold;
    assign in_hold   = fifo_lvl | (serving & {NUM_IN{out_stall}});

    assign out0_valid = ovalid;
    assign out0_data  = oword.data;
    assign out0_eop   = oword.eop;
    assign out0_eoe   = oword.eoe;
    assign out1_valid = ovalid;
    assign out1_data  = oword.data;
    assign out1_eop   = oword.eop;
    assign out1_eoe   = oword.eoe;

endmodule

// File: tb/evm_merger_tb.sv
module evm_merger_tb_top;
    import evm_pkg::*;

    localparam int N = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [N-1:0]      in_enable;
    logic [N-1:0]      in_valid;
    logic [N-1:0][20:0] in_data;
    logic [N-1:0]      in_eop;
    logic [N-1:0]      in_eoe;
    logic [N-1:0]      in_hold;
    logic              out0_valid, out0_eop, out0_eoe, out0_hold;
    logic              out1_valid, out1_eop, out1_eoe, out1_hold;
    logic [20:0]       out0_data, out1_data;

    evm_merger dut_i (
        .clk(clk), .rst_n(rst_n), .in_enable(in_enable), .in_valid(in_valid),
        .in_data(in_data), .in_eop(in_eop), .in_eoe(in_eoe), .in_hold(in_hold),
        .out0_valid(out0_valid), .out0_data(out0_data), .out0_eop(out0_eop),
        .out0_eoe(out0_eoe), .out0_hold(out0_hold),
        .out1_valid(out1_valid), .out1_data(out1_data), .out1_eop(out1_eop),
        .out1_eoe(out1_eoe), .out1_hold(out1_hold)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int xfer_cnt = 0;
    int stab_checks = 0;
    int stab_bad = 0;
    logic [22:0] exp_q[$];
    logic        rnd_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] mk_data(int ev, int src, int pk, int w);
        return 21'(((ev & 255) << 13) | ((src & 3) << 11) | ((pk & 15) << 7) | ((w & 15) << 3) | 5);
    endfunction
    function automatic int n_pk(int ev, int src);
        return 1 + ((ev + src) % 2);
    endfunction
    function automatic int p_len(int ev, int src, int pk);
        return 1 + ((ev + src + pk) % 3);
    endfunction

    task automatic push_exp(logic [20:0] d, logic eop, logic eoe);
        exp_q.push_back({d, eop, eoe});
    endtask
    task automatic push_src(int ev, int src);
        for (int pk = 0; pk < n_pk(ev, src); pk++)
            for (int w = 0; w < p_len(ev, src, pk); w++)
                push_exp(mk_data(ev, src, pk, w), (w == p_len(ev, src, pk) - 1), 1'b0);
    endtask
    task automatic push_eoe();
        push_exp(21'd0, 1'b0, 1'b1);
    endtask
    function automatic int src_words(int ev, int src);
        int s = 0;
        for (int pk = 0; pk < n_pk(ev, src); pk++) s += p_len(ev, src, pk);
        return s;
    endfunction

    task automatic send_word(int src, logic [20:0] d, logic eop, logic eoe);
        do begin
            @(negedge clk); #2;
        end while (in_hold[src]);
        in_valid[src] = 1'b1;
        in_data[src]  = d;
        in_eop[src]   = eop;
        in_eoe[src]   = eoe;
        @(negedge clk); #2;
        in_valid[src] = 1'b0;
    endtask
    task automatic drive_src(int ev, int src);
        for (int pk = 0; pk < n_pk(ev, src); pk++)
            for (int w = 0; w < p_len(ev, src, pk); w++)
                send_word(src, mk_data(ev, src, pk, w), (w == p_len(ev, src, pk) - 1), 1'b0);
        send_word(src, mk_data(ev, src, 15, 15), 1'b0, 1'b1);
    endtask

    task automatic wait_left(int left);
        int t = 0;
        while (exp_q.size() > left && t < 4000) begin
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
    endtask
    task automatic wait_drain();
        wait_left(0);
        repeat (6) @(negedge clk);
        check_eq("R4,R11 all expected words delivered", exp_q.size(), 0);
    endtask

    // scoreboard monitor
    logic        prev_v = 1'b0, prev_stall = 1'b0;
    logic [22:0] prev_w = '0;
    always begin
        @(negedge clk); #4;
        if (rst_n) begin
            if (prev_v && prev_stall) begin
                stab_checks++;
                if (!(out0_valid && {out0_data, out0_eop, out0_eoe} == prev_w)) stab_bad++;
            end
            if (out0_valid && !out0_hold && !out1_hold) begin
                logic [22:0] got;
                got = {out0_data, out0_eop, out0_eoe};
                xfer_cnt++;
                check_eq("R5 copy 1 equals copy 0", {out1_valid, out1_data, out1_eop, out1_eoe}, {1'b1, got});
                if (exp_q.size() == 0) begin
                    check_eq("R4 unexpected extra word", got, 23'h7fffff);
                end else begin
                    logic [22:0] e;
                    e = exp_q.pop_front();
                    check_eq("R2,R3,R4 output word", got, e);
                end
            end
            prev_v     = out0_valid;
            prev_stall = out0_hold | out1_hold;
            prev_w     = {out0_data, out0_eop, out0_eoe};
        end
    end

    // random output hold generator
    always begin
        @(negedge clk); #2;
        if (rnd_on) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out0_hold = lfsr[0] & lfsr[3];
            out1_hold = lfsr[5] & lfsr[9];
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        int base;
        rst_n = 1'b0; in_enable = '0; in_valid = '0; in_data = '0;
        in_eop = '0; in_eoe = '0; out0_hold = 1'b0; out1_hold = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check_eq("R1 valid low in reset", {out0_valid, out1_valid}, 0);
        check_eq("R1 holds low in reset", in_hold, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 valid low after reset", {out0_valid, out1_valid}, 0);
        check_eq("R1 holds low after reset", in_hold, 0);

        // R10: empty mask emits nothing, data stays buffered
        drive_src(50, 1);
        repeat (30) @(negedge clk);
        check_eq("R10 no output with empty mask", xfer_cnt, 0);
        check_eq("R10 valid low with empty mask", out0_valid, 0);
        push_src(50, 1); push_eoe();
        in_enable = 4'b0010;
        @(negedge clk); #2;
        in_enable = '0;
        wait_drain();

        // R3: all lanes, in-order drive
        in_enable = 4'b1111;
        for (int s = 0; s < N; s++) push_src(1, s);
        push_eoe();
        for (int s = 0; s < N; s++) drive_src(1, s);
        in_enable = '0;
        wait_drain();

        // R3/R10: lanes 1 and 3 only
        in_enable = 4'b1010;
        push_src(2, 1); push_src(2, 3); push_eoe();
        drive_src(2, 1); drive_src(2, 3);
        in_enable = '0;
        wait_drain();

        // R3: lanes 0 and 2, higher lane driven first
        in_enable = 4'b0101;
        push_src(3, 0); push_src(3, 2); push_eoe();
        drive_src(3, 2); drive_src(3, 0);
        in_enable = '0;
        wait_drain();

        // R9: lane 1 runs a full event ahead
        in_enable = 4'b0011;
        push_src(4, 0); push_src(4, 1); push_eoe();
        push_src(5, 0); push_src(5, 1); push_eoe();
        base = xfer_cnt;
        drive_src(4, 1); drive_src(5, 1);
        repeat (10) @(negedge clk);
        check_eq("R9 nothing before lane 0 data", xfer_cnt - base, 0);
        drive_src(4, 0); drive_src(5, 0);
        wait_left(src_words(5, 0) + src_words(5, 1) + 1);
        in_enable = '0;
        wait_drain();

        // R6: random output holds over two events on all lanes
        in_enable = 4'b1111;
        rnd_on = 1'b1;
        for (int s = 0; s < N; s++) push_src(6, s);
        push_eoe();
        for (int s = 0; s < N; s++) push_src(7, s);
        push_eoe();
        fork
            begin drive_src(6, 0); drive_src(7, 0); end
            begin drive_src(6, 1); drive_src(7, 1); end
            begin drive_src(6, 2); drive_src(7, 2); end
            begin drive_src(6, 3); drive_src(7, 3); end
        join
        wait_left(src_words(7, 0) + src_words(7, 1) + src_words(7, 2) + src_words(7, 3) + 1);
        in_enable = '0;
        wait_left(0);
        rnd_on = 1'b0;
        @(negedge clk);
        out0_hold = 1'b0; out1_hold = 1'b0;
        wait_drain();
        check_eq("R6 held cycles observed", (stab_checks > 0), 1);
        check_eq("R6 word stable while held", stab_bad, 0);

        // R7: fill-level hold on an idle lane
        for (int k = 0; k < 11; k++)
            send_word(3, mk_data(8, 3, k / 4, k % 4), (k % 4 == 3), 1'b0);
        check_eq("R7 hold low at 11 entries", in_hold[3], 0);
        send_word(3, mk_data(8, 3, 2, 3), 1'b1, 1'b0);
        check_eq("R7 hold high at 12 entries", in_hold[3], 1);
        check_eq("R7 other lanes unaffected", in_hold[2:0], 0);
        for (int k = 0; k < 12; k++)
            push_exp(mk_data(8, 3, k / 4, k % 4), (k % 4 == 3), 1'b0);
        push_eoe();
        in_enable = 4'b1000;
        @(negedge clk); #2;
        in_enable = '0;
        send_word(3, 21'd0, 1'b0, 1'b1);
        wait_drain();

        // R8: selected lane held by output backpressure
        in_enable = 4'b0001;
        out0_hold = 1'b1;
        push_exp(21'h0ABCDE, 1'b1, 1'b0); push_eoe();
        send_word(0, 21'h0ABCDE, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check_eq("R6 word presented while held", {out0_valid, out0_data}, {1'b1, 21'h0ABCDE});
        check_eq("R8 served lane held", in_hold[0], 1);
        check_eq("R8 other lanes not held", in_hold[3:1], 0);
        out0_hold = 1'b0; out1_hold = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R8 served lane held by copy 1", in_hold[0], 1);
        check_eq("R6 copy 1 still valid", out1_valid, 1);
        out1_hold = 1'b0;
        send_word(0, 21'd0, 1'b0, 1'b1);
        in_enable = '0;
        wait_drain();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule